// File: doc/BRIEF.md
# I2C Controller Event Flag Register

This block keeps the event flags of an I2C controller's first status register and clears them when software performs the matching register accesses. A bus engine drives one-cycle event pulses into it: start sent, stop seen, address matched or sent, second 10-bit address byte acknowledged, 10-bit header sent, byte completed, acknowledge failure, arbitration loss, bus error and overrun/underrun. A simple register bus supplies one-cycle access strobes: status-1 read, status-2 read, data read, data write, control-1 write and status-1 write with its write data. The block presents the assembled status word and three level signals the engine uses: data register empty, data register full, and the byte-hold request that drives clock stretching.

Four flags clear only after a two-step access. Software first reads status-1, then performs a specific second access. Each of these flags is a small state machine with three states. `SEQ_CLEAR` means the flag is 0. `SEQ_SET` means the flag is 1 and no status read has seen it. `SEQ_ARMED` means the flag is 1 and a status-1 read has seen it. The transitions are:

- `go_set`: `SEQ_CLEAR` moves to `SEQ_SET` on the set event.
- `go_arm`: `SEQ_SET` moves to `SEQ_ARMED` on a status-1 read.
- `go_done`: `SEQ_ARMED` moves to `SEQ_CLEAR` on the matching second access.
- `go_rearm`: `SEQ_ARMED` moves back to `SEQ_SET` when a set event coincides with the second access.
- `go_hwclr`: `SEQ_SET` or `SEQ_ARMED` moves to `SEQ_CLEAR` on a hardware clear (start or stop, for the byte flag only).
- `go_kill`: any state moves to `SEQ_CLEAR` while the peripheral is disabled.

The start flag follows the same pattern.

Top module: `i2c_evt_flags`

## Requirements
- R1: While `pe_en` is 0, every flag and every armed state clears on the next clock edge, and `sr1` reads 0. A flag seen by a status-1 read before the disable must be read again before its second access can clear it.
- R2: The error flags are bus error (bit 8), arbitration lost (bit 9), acknowledge failure (bit 10) and overrun (bit 11). Each is set by its event pulse. Each stays set until a status-1 write carries 0 in that bit. A written 1 leaves the flag unchanged, and reads do not clear it.
- R3: Data-empty (bit 7) sets when a byte completes in transmit mode (`tx_mode`=1). It clears on a data write, a start event or a stop event.
- R4: Data-full (bit 6) sets when a byte completes in receive mode. It clears on a data read or a data write.
- R5: With `no_stretch`=0, byte-finished (bit 2) sets in two cases. In transmit, a byte completes while data-empty is already 1. In receive, a byte completes while data-full is already 1. With `no_stretch`=1 it never sets.
- R6: Byte-finished clears after a status-1 read followed by a data read or a data write. It also clears on a start or stop event. A data access without the prior status read leaves it set.
- R7: Stop-seen (bit 4) sets on a stop event. It clears only after a status-1 read followed by a control-1 write.
- R8: Header-sent (bit 3) sets on the 10-bit header event. It clears only after a status-1 read followed by a data write.
- R9: Address (bit 1) clears only after a status-1 read followed by a status-2 read.
- R10: With `ten_bit_master`=1, address sets only on `ev_addr_ack2` and ignores `ev_addr`. With `ten_bit_master`=0, it sets only on `ev_addr`.
- R11: Start (bit 0) sets on a start event. It clears after a status-1 read followed by a data write.
- R12: A status-1 read arms only the flags that are set at that read. An armed flag stays armed across unrelated accesses. A flag set after the read is not cleared by the next second access.
- R13: When a set event and a software clear of the same flag fall in one cycle, the flag stays set. For a two-step flag, the arming is consumed.
- R14: Bits 5 and 15:12 read 0. Status-1 writes have no effect on bits 7:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pe_en | input | 1 | Peripheral enable; 0 clears all flags |
| no_stretch | input | 1 | 1 disables clock stretching (byte-finished never sets) |
| tx_mode | input | 1 | 1 transmit, 0 receive |
| ten_bit_master | input | 1 | 1 when mastering with a 10-bit address |
| ev_start | input | 1 | Start condition sent |
| ev_stop | input | 1 | Stop condition detected |
| ev_addr | input | 1 | Address matched or sent |
| ev_addr_ack2 | input | 1 | Second 10-bit address byte acknowledged |
| ev_hdr10 | input | 1 | 10-bit header byte sent |
| ev_byte_done | input | 1 | Data byte completed |
| ev_ack_fail | input | 1 | Acknowledge failure |
| ev_arb_lost | input | 1 | Arbitration lost |
| ev_bus_err | input | 1 | Misplaced start or stop |
| ev_ovr | input | 1 | Overrun or underrun |
| rd_sr1 | input | 1 | Status-1 read strobe |
| rd_sr2 | input | 1 | Status-2 read strobe |
| rd_dr | input | 1 | Data register read strobe |
| wr_dr | input | 1 | Data register write strobe |
| wr_cr1 | input | 1 | Control-1 write strobe |
| wr_sr1 | input | 1 | Status-1 write strobe |
| wdata | input | REG_W | Write data for status-1 writes |
| sr1 | output | REG_W | Status-1 value |
| dr_empty | output | 1 | Data-empty flag to the engine |
| dr_full | output | 1 | Data-full flag to the engine |
| byte_hold | output | 1 | Byte-finished flag, requests clock stretch |

## Verification
A two-step flag stuck in `SEQ_SET` shows up on `sr1` as a bit that survives its second access one cycle after that access. A flag wrongly left in `SEQ_ARMED` shows up as a bit that vanishes on a second access that no status read preceded. A wrong set/clear priority drops a flag bit in the cycle after the coinciding event, and the bit never returns. A wrong byte-finished condition appears on `byte_hold` one cycle after the second byte completion, and it stays wrong until a start, stop or two-step clear.

// File: rtl/i2c_evt_pkg.sv
package i2c_evt_pkg;

    typedef enum logic [1:0] {
        SEQ_CLEAR = 2'd0,
        SEQ_SET   = 2'd1,
        SEQ_ARMED = 2'd2
    } seq_state_t;

    // status word bit positions (software decodes these)
    localparam int B_SB    = 0;
    localparam int B_ADDR  = 1;
    localparam int B_BTF   = 2;
    localparam int B_HDR   = 3;
    localparam int B_STOP  = 4;
    localparam int B_FULL  = 6;
    localparam int B_EMPTY = 7;
    localparam int B_ERR0  = 8;

    // indices into the two-step flag array
    localparam int SQ_SB   = 0;
    localparam int SQ_ADDR = 1;
    localparam int SQ_BTF  = 2;
    localparam int SQ_HDR  = 3;
    localparam int SQ_STOP = 4;
    localparam int N_SEQ   = 5;

    // indices into the write-zero error array
    localparam int ER_BUS  = 0;
    localparam int ER_ARB  = 1;
    localparam int ER_ACK  = 2;
    localparam int ER_OVR  = 3;
    localparam int N_ERR   = 4;

endpackage

// File: rtl/i2c_seq_flag.sv
module i2c_seq_flag
    import i2c_evt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic kill,
    input  logic set_ev,
    input  logic arm,
    input  logic second,
    input  logic hw_clr,
    output logic flag
);

    seq_state_t st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= SEQ_CLEAR;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        if (kill) begin
            st_d = SEQ_CLEAR;                                 // go_kill
        end else begin
            unique case (st_q)
                SEQ_CLEAR: if (set_ev) st_d = SEQ_SET;        // go_set
                SEQ_SET: begin
                    if (set_ev)      st_d = arm ? SEQ_ARMED : SEQ_SET;
                    else if (hw_clr) st_d = SEQ_CLEAR;        // go_hwclr
                    else if (arm)    st_d = SEQ_ARMED;        // go_arm
                end
                SEQ_ARMED: begin
                    if (set_ev)                st_d = second ? SEQ_SET : SEQ_ARMED; // go_rearm
                    else if (hw_clr || second) st_d = SEQ_CLEAR; // go_hwclr / go_done
                end
                default: st_d = SEQ_CLEAR;
            endcase
        end
    end

    always_comb begin
        flag = (st_q != SEQ_CLEAR);
    end

    assert_set_wins_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (set_ev && !kill) |=> flag);

    assert_unarmed_holds_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == SEQ_SET && !set_ev && !hw_clr && !arm && !kill) |=> (flag && st_q == SEQ_SET));

    assert_armed_clears_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == SEQ_ARMED && second && !set_ev && !kill) |=> !flag);

endmodule

// File: rtl/i2c_err_flags.sv
module i2c_err_flags #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         kill,
    input  logic [N-1:0] set_ev,
    input  logic         wr,
    input  logic [N-1:0] wbits,
    output logic [N-1:0] flags
);

    for (genvar i = 0; i < N; i++) begin : g_err
        logic q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         q <= 1'b0;
            else if (kill)      q <= 1'b0;
            else if (set_ev[i]) q <= 1'b1;
            else if (wr && !wbits[i]) q <= 1'b0;
        end
        assign flags[i] = q;

        assert_err_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (flags[i] && !(wr && !wbits[i]) && !kill) |=> flags[i]);

        assert_err_wclr_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (wr && !wbits[i] && !set_ev[i] && !kill) |=> !flags[i]);
    end

endmodule

// File: rtl/i2c_evt_flags.sv
module i2c_evt_flags
    import i2c_evt_pkg::*;
#(
    parameter int REG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pe_en,
    input  logic             no_stretch,
    input  logic             tx_mode,
    input  logic             ten_bit_master,
    input  logic             ev_start,
    input  logic             ev_stop,
    input  logic             ev_addr,
    input  logic             ev_addr_ack2,
    input  logic             ev_hdr10,
    input  logic             ev_byte_done,
    input  logic             ev_ack_fail,
    input  logic             ev_arb_lost,
    input  logic             ev_bus_err,
    input  logic             ev_ovr,
    input  logic             rd_sr1,
    input  logic             rd_sr2,
    input  logic             rd_dr,
    input  logic             wr_dr,
    input  logic             wr_cr1,
    input  logic             wr_sr1,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] sr1,
    output logic             dr_empty,
    output logic             dr_full,
    output logic             byte_hold
);

    localparam int ERR_HI = B_ERR0 + N_ERR - 1;

    logic kill;
    logic empty_q, full_q;
    logic [N_SEQ-1:0] sq_set, sq_second, sq_hwclr, sq_flag;
    logic [N_ERR-1:0] er_set, er_flag;
    logic wdata_unused;

    assign kill = !pe_en;
    assign wdata_unused = ^{wdata[REG_W-1:ERR_HI+1], wdata[B_ERR0-1:0]};

    // data register empty / full
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            empty_q <= 1'b0;
            full_q  <= 1'b0;
        end else if (kill) begin
            empty_q <= 1'b0;
            full_q  <= 1'b0;
        end else begin
            if (ev_byte_done && tx_mode)           empty_q <= 1'b1;
            else if (wr_dr || ev_start || ev_stop) empty_q <= 1'b0;
            if (ev_byte_done && !tx_mode)          full_q <= 1'b1;
            else if (rd_dr || wr_dr)               full_q <= 1'b0;
        end
    end

    // two-step flag event routing
    always_comb begin
        sq_set    = '0;
        sq_second = '0;
        sq_hwclr  = '0;
        sq_set[SQ_SB]      = ev_start;
        sq_second[SQ_SB]   = wr_dr;
        sq_set[SQ_ADDR]    = ten_bit_master ? ev_addr_ack2 : ev_addr;
        sq_second[SQ_ADDR] = rd_sr2;
        sq_set[SQ_BTF]     = ev_byte_done && !no_stretch && (tx_mode ? empty_q : full_q);
        sq_second[SQ_BTF]  = rd_dr || wr_dr;
        sq_hwclr[SQ_BTF]   = ev_start || ev_stop;
        sq_set[SQ_HDR]     = ev_hdr10;
        sq_second[SQ_HDR]  = wr_dr;
        sq_set[SQ_STOP]    = ev_stop;
        sq_second[SQ_STOP] = wr_cr1;
    end

    for (genvar k = 0; k < N_SEQ; k++) begin : g_seq
        i2c_seq_flag u_seq (
            .clk    (clk),
            .rst_n  (rst_n),
            .kill   (kill),
            .set_ev (sq_set[k]),
            .arm    (rd_sr1),
            .second (sq_second[k]),
            .hw_clr (sq_hwclr[k]),
            .flag   (sq_flag[k])
        );
    end

    always_comb begin
        er_set = '0;
        er_set[ER_BUS] = ev_bus_err;
        er_set[ER_ARB] = ev_arb_lost;
        er_set[ER_ACK] = ev_ack_fail;
        er_set[ER_OVR] = ev_ovr;
    end

    i2c_err_flags #(.N(N_ERR)) u_err (
        .clk    (clk),
        .rst_n  (rst_n),
        .kill   (kill),
        .set_ev (er_set),
        .wr     (wr_sr1),
        .wbits  (wdata[ERR_HI:B_ERR0]),
        .flags  (er_flag)
    );

    // status word assembly; unlisted bits read 0
    always_comb begin
        sr1 = '0;
        sr1[B_SB]    = sq_flag[SQ_SB];
        sr1[B_ADDR]  = sq_flag[SQ_ADDR];
        sr1[B_BTF]   = sq_flag[SQ_BTF];
        sr1[B_HDR]   = sq_flag[SQ_HDR];
        sr1[B_STOP]  = sq_flag[SQ_STOP];
        sr1[B_FULL]  = full_q;
        sr1[B_EMPTY] = empty_q;
        sr1[ERR_HI:B_ERR0] = er_flag;
        dr_empty  = empty_q;
        dr_full   = full_q;
        byte_hold = sq_flag[SQ_BTF];
    end

    assert_disable_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !pe_en |=> (sr1 == '0));

    assert_tx_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pe_en && ev_byte_done && tx_mode) |=> dr_empty);

    assert_rx_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pe_en && ev_byte_done && !tx_mode) |=> dr_full);

    assert_no_stretch_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (no_stretch && !byte_hold) |=> !byte_hold);

endmodule

// File: tb/sim_i2c_evt_flags.sv
`timescale 1ns/1ps
module sim_i2c_evt_flags;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pe_en = 1'b0, no_stretch = 1'b0, tx_mode = 1'b1, ten_bit_master = 1'b0;
    logic ev_start = 0, ev_stop = 0, ev_addr = 0, ev_addr_ack2 = 0, ev_hdr10 = 0;
    logic ev_byte_done = 0, ev_ack_fail = 0, ev_arb_lost = 0, ev_bus_err = 0, ev_ovr = 0;
    logic rd_sr1 = 0, rd_sr2 = 0, rd_dr = 0, wr_dr = 0, wr_cr1 = 0, wr_sr1 = 0;
    logic [15:0] wdata = '0;
    logic [15:0] sr1;
    logic dr_empty, dr_full, byte_hold;
    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    i2c_evt_flags u0 (.*);

    // actions
    localparam int A_NOP = 0, A_START = 1, A_STOP = 2, A_ADDR = 3, A_HDR = 4, A_BDONE = 5;
    localparam int A_AF = 6, A_ARLO = 7, A_BERR = 8, A_OVR = 9, A_RSR1 = 10, A_RSR2 = 11;
    localparam int A_RDR = 12, A_WDR = 13, A_WCR1 = 14, A_WSR1_0 = 15, A_WSR1_AF = 16;
    localparam int A_ACK2 = 17, A_WSR1_1 = 18;

    // {tx_mode, action[4:0], req[3:0], 6'b0, expected sr1[15:0]}
    localparam logic [31:0] VEC [36] = '{
        {1'b1, 5'd1,  4'd11, 6'd0, 16'h0001},  // R11 start
        {1'b1, 5'd10, 4'd11, 6'd0, 16'h0001},  // R11 read arms
        {1'b1, 5'd13, 4'd11, 6'd0, 16'h0000},  // R11 data write clears
        {1'b1, 5'd3,  4'd9,  6'd0, 16'h0002},  // R9 address
        {1'b1, 5'd10, 4'd9,  6'd0, 16'h0002},  // R9
        {1'b1, 5'd12, 4'd12, 6'd0, 16'h0002},  // R12 unrelated access keeps arm
        {1'b1, 5'd11, 4'd9,  6'd0, 16'h0000},  // R9 status-2 read clears
        {1'b1, 5'd5,  4'd3,  6'd0, 16'h0080},  // R3 empty sets
        {1'b1, 5'd5,  4'd5,  6'd0, 16'h0084},  // R5 tx byte-finished
        {1'b1, 5'd14, 4'd6,  6'd0, 16'h0084},  // R6 unrelated write
        {1'b1, 5'd13, 4'd6,  6'd0, 16'h0004},  // R6 no arm: stays; R3 empty clears
        {1'b1, 5'd10, 4'd6,  6'd0, 16'h0004},  // R6
        {1'b1, 5'd13, 4'd6,  6'd0, 16'h0000},  // R6 cleared
        {1'b1, 5'd5,  4'd3,  6'd0, 16'h0080},  // R3
        {1'b1, 5'd2,  4'd7,  6'd0, 16'h0010},  // R7 stop sets, R3 stop clears empty
        {1'b1, 5'd14, 4'd7,  6'd0, 16'h0010},  // R7 no read first
        {1'b1, 5'd10, 4'd7,  6'd0, 16'h0010},  // R7
        {1'b1, 5'd14, 4'd7,  6'd0, 16'h0000},  // R7 cleared
        {1'b0, 5'd5,  4'd4,  6'd0, 16'h0040},  // R4 full sets
        {1'b0, 5'd5,  4'd5,  6'd0, 16'h0044},  // R5 rx byte-finished
        {1'b0, 5'd12, 4'd4,  6'd0, 16'h0004},  // R4 read clears full
        {1'b0, 5'd10, 4'd6,  6'd0, 16'h0004},  // R6
        {1'b0, 5'd12, 4'd6,  6'd0, 16'h0000},  // R6 read clears
        {1'b1, 5'd6,  4'd2,  6'd0, 16'h0400},  // R2 ack fail
        {1'b1, 5'd7,  4'd2,  6'd0, 16'h0600},  // R2 arb lost
        {1'b1, 5'd8,  4'd2,  6'd0, 16'h0700},  // R2 bus error
        {1'b1, 5'd9,  4'd2,  6'd0, 16'h0F00},  // R2 overrun
        {1'b1, 5'd10, 4'd2,  6'd0, 16'h0F00},  // R2 read keeps
        {1'b1, 5'd4,  4'd8,  6'd0, 16'h0F08},  // R8 header
        {1'b1, 5'd10, 4'd8,  6'd0, 16'h0F08},  // R8
        {1'b1, 5'd13, 4'd8,  6'd0, 16'h0F00},  // R8 cleared
        {1'b1, 5'd16, 4'd2,  6'd0, 16'h0B00},  // R2 write zero in bit 10 only
        {1'b1, 5'd15, 4'd2,  6'd0, 16'h0000},  // R2 write zeros
        {1'b1, 5'd5,  4'd3,  6'd0, 16'h0080},  // R3
        {1'b1, 5'd15, 4'd14, 6'd0, 16'h0080},  // R14 write ignored on bit 7
        {1'b1, 5'd13, 4'd3,  6'd0, 16'h0000}   // R3
    };

    task automatic idle_all();
        ev_start = 0; ev_stop = 0; ev_addr = 0; ev_addr_ack2 = 0; ev_hdr10 = 0;
        ev_byte_done = 0; ev_ack_fail = 0; ev_arb_lost = 0; ev_bus_err = 0; ev_ovr = 0;
        rd_sr1 = 0; rd_sr2 = 0; rd_dr = 0; wr_dr = 0; wr_cr1 = 0; wr_sr1 = 0; wdata = '0;
    endtask

    task automatic set_act(input int act);
        case (act)
            A_START:   ev_start = 1;
            A_STOP:    ev_stop = 1;
            A_ADDR:    ev_addr = 1;
            A_HDR:     ev_hdr10 = 1;
            A_BDONE:   ev_byte_done = 1;
            A_AF:      ev_ack_fail = 1;
            A_ARLO:    ev_arb_lost = 1;
            A_BERR:    ev_bus_err = 1;
            A_OVR:     ev_ovr = 1;
            A_RSR1:    rd_sr1 = 1;
            A_RSR2:    rd_sr2 = 1;
            A_RDR:     rd_dr = 1;
            A_WDR:     wr_dr = 1;
            A_WCR1:    wr_cr1 = 1;
            A_WSR1_0:  begin wr_sr1 = 1; wdata = 16'h0000; end
            A_WSR1_AF: begin wr_sr1 = 1; wdata = 16'hFBFF; end
            A_ACK2:    ev_addr_ack2 = 1;
            A_WSR1_1:  begin wr_sr1 = 1; wdata = 16'hFFFF; end
            default: ;
        endcase
    endtask

    // drive one action for one cycle; returns at the following negedge
    task automatic drive(input int act, input logic txm);
        @(negedge clk);
        tx_mode = txm;
        set_act(act);
        @(negedge clk);
        idle_all();
    endtask

    task automatic chk(input logic [15:0] exp, input string tag);
        checks++;
        if (sr1 !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, sr1, exp);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R1 actual timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        idle_all();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        pe_en = 1'b1;
        @(negedge clk);
        chk(16'h0000, "R1 reset state");

        for (int i = 0; i < 36; i++) begin
            drive(int'(VEC[i][30:26]), VEC[i][31]);
            chk(VEC[i][15:0], $sformatf("R%0d vector %0d", VEC[i][25:22], i));
        end

        // R1: disable clears flags and drops arming
        drive(A_STOP, 1'b1);
        drive(A_AF, 1'b1);
        chk(16'h0410, "R1 setup");
        drive(A_RSR1, 1'b1);
        @(negedge clk); pe_en = 1'b0;
        @(negedge clk); pe_en = 1'b1;
        chk(16'h0000, "R1 disable");
        drive(A_STOP, 1'b1);
        drive(A_WCR1, 1'b1);
        chk(16'h0010, "R1 arm dropped");
        drive(A_RSR1, 1'b1);
        drive(A_WCR1, 1'b1);
        chk(16'h0000, "R1 cleanup");

        // R5: no stretch
        no_stretch = 1'b1;
        drive(A_BDONE, 1'b1);
        drive(A_BDONE, 1'b1);
        chk(16'h0080, "R5 no_stretch");
        drive(A_WDR, 1'b1);
        no_stretch = 1'b0;
        chk(16'h0000, "R5 cleanup");

        // R10: ten-bit master address gating
        ten_bit_master = 1'b1;
        drive(A_ADDR, 1'b1);
        chk(16'h0000, "R10 first byte ignored");
        drive(A_ACK2, 1'b1);
        chk(16'h0002, "R10 second ack sets");
        drive(A_RSR1, 1'b1);
        drive(A_RSR2, 1'b1);
        ten_bit_master = 1'b0;
        drive(A_ACK2, 1'b1);
        chk(16'h0000, "R10 ack2 ignored in 7-bit");

        // R12: flag set after the read is not armed
        drive(A_RSR1, 1'b1);
        drive(A_STOP, 1'b1);
        drive(A_WCR1, 1'b1);
        chk(16'h0010, "R12 late flag not armed");
        drive(A_RSR1, 1'b1);
        drive(A_WCR1, 1'b1);
        chk(16'h0000, "R12 cleanup");

        // R13: set wins
        drive(A_STOP, 1'b1);
        drive(A_RSR1, 1'b1);
        @(negedge clk); ev_stop = 1; wr_cr1 = 1;
        @(negedge clk); idle_all();
        chk(16'h0010, "R13 set beats two-step clear");
        drive(A_WCR1, 1'b1);
        chk(16'h0010, "R13 arming consumed");
        drive(A_RSR1, 1'b1);
        drive(A_WCR1, 1'b1);
        @(negedge clk); ev_ack_fail = 1; wr_sr1 = 1; wdata = 16'h0000;
        @(negedge clk); idle_all();
        chk(16'h0400, "R13 set beats write-zero");
        drive(A_WSR1_0, 1'b1);
        chk(16'h0000, "R13 cleanup");

        // R3: start clears empty
        drive(A_BDONE, 1'b1);
        drive(A_START, 1'b1);
        chk(16'h0001, "R3 start clears empty");
        drive(A_RSR1, 1'b1);
        drive(A_WDR, 1'b1);
        chk(16'h0000, "R11 cleanup");

        // R14: writes to read-only bits
        drive(A_WSR1_1, 1'b1);
        chk(16'h0000, "R14 write ones ignored");
        drive(A_BDONE, 1'b0);
        drive(A_WSR1_1, 1'b0);
        chk(16'h0040, "R14 full unaffected");

        // R4: data write clears full
        drive(A_WDR, 1'b0);
        chk(16'h0000, "R4 write clears full");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule